// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block lets on-chip logic program and erase an 8-bit parallel NOR-style flash. It takes a request with an operation code, an address and a data byte and turns it into the fixed series of unlock and command writes that such a device expects. It supports three operations: byte program, whole-device erase and single-sector erase. After the final write it reads the device repeatedly and checks data bit 7 to find out when the internal operation has finished.

When bit 7 shows completion, or when a programmable number of status reads has passed without it, the block raises a one-cycle done pulse. The pulse is flagged as an error in the timeout case. The flash side has a separate output data bus with a drive enable, an input data bus, active-low write-enable and active-low output-enable. Board-level timing margins and multiplexed address latching are outside this block.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is held and right after it, busy_o, done_o and error_o are 0, fl_we_no and fl_oe_no are 1, and fl_data_oe_o is 0.
- R2: A request is accepted only when the block is idle and req_op_i is 0 (byte program), 1 (whole-device erase) or 2 (sector erase). Code 3 is ignored, as is any request made while busy_o is 1. Accepting a request sets busy_o in the next cycle.
- R3: Byte program issues four writes, as (address, data): (5555h, AAh), (2AAAh, 55h), (5555h, A0h), then the request data to the request address.
- R4: Whole-device erase issues six writes: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), (5555h, 10h).
- R5: Sector erase issues the same first five writes as R4. Its sixth write is 30h to the request address.
- R6: Each write takes three phases. A setup phase lasts one cycle, with write-enable high and the new address and data driven. A low phase lasts WE_LO_CYC cycles. A high phase lasts WE_HI_CYC cycles. Address and data stay unchanged from the setup phase to the end of the high phase. The data driver is on, and output-enable is high, during every write phase.
- R7: Each status read drives the request address and holds output-enable low for RD_CYC cycles. Bit 7 is sampled in the last of those cycles. One cycle with output-enable high follows before the next read or the end of the operation.
- R8: A program completes at the first status read whose bit 7 equals bit 7 of the request data.
- R9: An erase completes at the first status read whose bit 7 is 1.
- R10: If max(poll_limit_i, 1) status reads pass without completion, the operation ends with error_o set. poll_limit_i is sampled when the request is accepted.
- R11: done_o is high for exactly one cycle. That cycle comes S*(1+WE_LO_CYC+WE_HI_CYC) + P*(RD_CYC+1) cycles after the first busy cycle, where S is the number of writes and P the number of reads. error_o is high only together with done_o. busy_o is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 2 | Operation: 0 program, 1 whole-device erase, 2 sector erase |
| req_addr_i | input | ADDR_W | Program address or sector address |
| req_data_i | input | 8 | Byte to program |
| poll_limit_i | input | POLL_W | Maximum status reads (0 treated as 1) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Timeout, valid with done_o |
| fl_addr_o | output | ADDR_W | Flash address |
| fl_data_o | output | 8 | Flash write data |
| fl_data_oe_o | output | 1 | Write data driver enable |
| fl_data_i | input | 8 | Flash read data |
| fl_we_no | output | 1 | Flash write enable, active low |
| fl_oe_no | output | 1 | Flash output enable, active low |

## Verification
A wrong step counter or opcode latch shows up on the pins at once. The write that follows it carries the wrong address or data, or the operation has the wrong number of write-enable pulses. A phase counter that is off by one shifts the done pulse by a predictable number of cycles per write or per read, so each run's done cycle is compared exactly against the formula in R11. Mistakes in sampling bit 7, comparing it, or counting polls change the number of output-enable pulses and the error flag at the end of the operation. Sweeping every operation against every mix of slow-device reads and poll limits exposes these mistakes.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_CHIP = 2'd1,
    OP_SECT = 2'd2,
    OP_RSVD = 2'd3
  } flash_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WLO,
    ST_WHI,
    ST_RLO,
    ST_EVAL,
    ST_FIN
  } seq_state_e;

  localparam logic [15:0] ULK_ADDR_A = 16'h5555;
  localparam logic [15:0] ULK_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  ULK_CODE_A = 8'hAA;
  localparam logic [7:0]  ULK_CODE_B = 8'h55;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;
  localparam logic [7:0]  CMD_ERASE  = 8'h80;
  localparam logic [7:0]  CMD_CHIP   = 8'h10;
  localparam logic [7:0]  CMD_SECT   = 8'h30;
  localparam int unsigned STEP_W     = 3;
endpackage

// File: rtl/flash_cmd_table.sv
module flash_cmd_table
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  flash_op_e                  op_i,
  input  logic [STEP_W-1:0]          step_i,
  input  logic [ADDR_W-1:0]          tgt_addr_i,
  input  logic [7:0]                 tgt_data_i,
  output logic [ADDR_W-1:0]          addr_o,
  output logic [7:0]                 data_o,
  output logic                       last_o
);
  localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(ULK_ADDR_A);
  localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(ULK_ADDR_B);
  localparam logic [STEP_W-1:0] LAST_PROG  = STEP_W'(3);
  localparam logic [STEP_W-1:0] LAST_ERASE = STEP_W'(5);

  logic is_prog, is_sect;
  assign is_prog = (op_i == OP_PROG);
  assign is_sect = (op_i == OP_SECT);

  always_comb begin
    addr_o = ADR_A;
    data_o = ULK_CODE_A;
    unique case (step_i)
      3'd0: begin addr_o = ADR_A; data_o = ULK_CODE_A; end
      3'd1: begin addr_o = ADR_B; data_o = ULK_CODE_B; end
      3'd2: begin addr_o = ADR_A; data_o = is_prog ? CMD_PROG : CMD_ERASE; end
      3'd3: begin
        addr_o = is_prog ? tgt_addr_i : ADR_A;
        data_o = is_prog ? tgt_data_i : ULK_CODE_A;
      end
      3'd4: begin addr_o = ADR_B; data_o = ULK_CODE_B; end
      3'd5: begin
        addr_o = is_sect ? tgt_addr_i : ADR_A;
        data_o = is_sect ? CMD_SECT : CMD_CHIP;
      end
      default: begin addr_o = ADR_A; data_o = ULK_CODE_A; end
    endcase
  end

  assign last_o = is_prog ? (step_i == LAST_PROG) : (step_i == LAST_ERASE);
endmodule

// File: rtl/flash_phase_timer.sv
module flash_phase_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  assign last_o = (cnt_q == len_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (!last_o) cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/flash_poll_unit.sv
module flash_poll_unit #(
  parameter int unsigned POLL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [POLL_W-1:0] limit_i,
  input  logic              sample_i,
  input  logic              bit_i,
  input  logic              expect_i,
  input  logic              eval_i,
  output logic              match_o,
  output logic              exhausted_o
);
  logic [POLL_W-1:0] lim_q, cnt_q;
  logic              bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q <= POLL_W'(1);
      cnt_q <= '0;
      bit_q <= 1'b0;
    end else begin
      if (start_i) begin
        lim_q <= (limit_i == '0) ? POLL_W'(1) : limit_i;
        cnt_q <= '0;
      end else if (eval_i) begin
        cnt_q <= cnt_q + POLL_W'(1);
      end
      if (sample_i) bit_q <= bit_i;
    end
  end

  assign match_o     = (bit_q == expect_i);
  // compare one bit wider so cnt+1 cannot wrap
  assign exhausted_o = ({1'b0, cnt_q} + (POLL_W+1)'(1)) >= {1'b0, lim_q};
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned WE_LO_CYC = 2,
  parameter int unsigned WE_HI_CYC = 2,
  parameter int unsigned RD_CYC    = 2,
  parameter int unsigned POLL_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_data_i,
  input  logic [POLL_W-1:0] poll_limit_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_data_o,
  output logic              fl_data_oe_o,
  input  logic [7:0]        fl_data_i,
  output logic              fl_we_no,
  output logic              fl_oe_no
);
  localparam int unsigned MAX_WR  = (WE_LO_CYC > WE_HI_CYC) ? WE_LO_CYC : WE_HI_CYC;
  localparam int unsigned MAX_CYC = (MAX_WR > RD_CYC) ? MAX_WR : RD_CYC;
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC + 1);

  seq_state_e        state_q, state_d;
  flash_op_e         op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [STEP_W-1:0] step_q;
  logic              err_q;

  logic              accept;
  logic [CNT_W-1:0]  phase_len;
  logic              phase_last;
  logic [ADDR_W-1:0] tbl_addr;
  logic [7:0]        tbl_data;
  logic              tbl_last;
  logic              poll_match, poll_exhausted;
  logic              writing, reading;
  logic              unused_rd_bits;

  assign unused_rd_bits = ^fl_data_i[6:0];

  assign accept = (state_q == ST_IDLE) && req_valid_i && (flash_op_e'(req_op_i) != OP_RSVD);

  flash_cmd_table #(.ADDR_W(ADDR_W)) u_table (
    .op_i       (op_q),
    .step_i     (step_q),
    .tgt_addr_i (addr_q),
    .tgt_data_i (data_q),
    .addr_o     (tbl_addr),
    .data_o     (tbl_data),
    .last_o     (tbl_last)
  );

  always_comb begin
    unique case (state_q)
      ST_WLO:  phase_len = CNT_W'(WE_LO_CYC);
      ST_WHI:  phase_len = CNT_W'(WE_HI_CYC);
      ST_RLO:  phase_len = CNT_W'(RD_CYC);
      default: phase_len = CNT_W'(1);
    endcase
  end

  flash_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_d != state_q),
    .len_i  (phase_len),
    .last_o (phase_last)
  );

  flash_poll_unit #(.POLL_W(POLL_W)) u_poll (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .limit_i     (poll_limit_i),
    .sample_i    ((state_q == ST_RLO) && phase_last),
    .bit_i       (fl_data_i[7]),
    .expect_i    ((op_q == OP_PROG) ? data_q[7] : 1'b1),
    .eval_i      (state_q == ST_EVAL),
    .match_o     (poll_match),
    .exhausted_o (poll_exhausted)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_SETUP;
      ST_SETUP: state_d = ST_WLO;
      ST_WLO:   if (phase_last) state_d = ST_WHI;
      ST_WHI:   if (phase_last) state_d = tbl_last ? ST_RLO : ST_SETUP;
      ST_RLO:   if (phase_last) state_d = ST_EVAL;
      ST_EVAL:  state_d = (poll_match || poll_exhausted) ? ST_FIN : ST_RLO;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
      step_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q   <= flash_op_e'(req_op_i);
        addr_q <= req_addr_i;
        data_q <= req_data_i;
        step_q <= '0;
        err_q  <= 1'b0;
      end
      if (state_q == ST_WHI && phase_last && !tbl_last) step_q <= step_q + STEP_W'(1);
      if (state_q == ST_EVAL) err_q <= !poll_match;
    end
  end

  assign writing      = (state_q == ST_SETUP) || (state_q == ST_WLO) || (state_q == ST_WHI);
  assign reading      = (state_q == ST_RLO) || (state_q == ST_EVAL);
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_FIN);
  assign error_o      = done_o && err_q;
  assign fl_we_no     = (state_q != ST_WLO);
  assign fl_oe_no     = (state_q != ST_RLO);
  assign fl_data_oe_o = writing;
  assign fl_data_o    = writing ? tbl_data : 8'h00;
  assign fl_addr_o    = writing ? tbl_addr : (reading ? addr_q : '0);
endmodule

// File: rtl/flash_cmd_seq_checker.sv
module flash_cmd_seq_checker #(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        req_op_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              error_o,
  input logic [ADDR_W-1:0] fl_addr_o,
  input logic [7:0]        fl_data_o,
  input logic              fl_data_oe_o,
  input logic              fl_we_no,
  input logic              fl_oe_no
);
  assert_idle_pins_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (fl_we_no && fl_oe_no && !fl_data_oe_o && !done_o));

  assert_rsvd_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && req_op_i == 2'd3) |=> !busy_o);

  assert_idle_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && req_op_i != 2'd3) |=> busy_o);

  assert_wr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_we_no && $past(!fl_we_no)) |-> ($stable(fl_addr_o) && $stable(fl_data_o)));

  assert_wr_rise_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fl_we_no) |-> ($stable(fl_addr_o) && $stable(fl_data_o) && fl_data_oe_o));

  assert_drive_no_oe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_data_oe_o |-> fl_oe_no);

  assert_we_oe_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fl_we_no == 1'b0 && fl_oe_no == 1'b0));

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  assert_err_with_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> done_o);

  assert_busy_end_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o));
endmodule

bind flash_cmd_seq flash_cmd_seq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_op_i     (req_op_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .error_o      (error_o),
  .fl_addr_o    (fl_addr_o),
  .fl_data_o    (fl_data_o),
  .fl_data_oe_o (fl_data_oe_o),
  .fl_we_no     (fl_we_no),
  .fl_oe_no     (fl_oe_no)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  localparam int AW = 20;
  localparam int LO = 2;
  localparam int HI = 2;
  localparam int RC = 2;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic [PW-1:0] poll_limit = '0;
  logic          busy, done, err, data_oe, we_n, oe_n;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_wdata, fl_rdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic          rec_en = 1'b0;
  int            wr_n, rd_n, rd_bad, busy_reads;
  logic [AW-1:0] wr_a [8];
  logic [7:0]    wr_d [8];
  logic [AW-1:0] lat_a, exp_rd_a;
  logic [7:0]    busy_val, ready_val;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_cmd_seq u_flash_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_data_i(req_data), .poll_limit_i(poll_limit),
    .busy_o(busy), .done_o(done), .error_o(err), .fl_addr_o(fl_addr),
    .fl_data_o(fl_wdata), .fl_data_oe_o(data_oe), .fl_data_i(fl_rdata),
    .fl_we_no(we_n), .fl_oe_no(oe_n)
  );

  // flash device model
  always @(negedge we_n) if (rec_en) lat_a = fl_addr;
  always @(posedge we_n) if (rec_en) begin
    if (wr_n < 8) begin wr_a[wr_n] = lat_a; wr_d[wr_n] = fl_wdata; end
    wr_n++;
  end
  always @(negedge oe_n) if (rec_en) begin
    rd_n++;
    if (fl_addr != exp_rd_a) rd_bad++;
  end
  assign fl_rdata = (rd_n <= busy_reads) ? busy_val : ready_val;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_wa(input int op, input int k, input logic [AW-1:0] a);
    case (k)
      0, 2: return AW'(20'h05555);
      1, 4: return AW'(20'h02AAA);
      3: return (op == 0) ? a : AW'(20'h05555);
      default: return (op == 2) ? a : AW'(20'h05555);
    endcase
  endfunction

  function automatic logic [7:0] exp_wd(input int op, input int k, input logic [7:0] d);
    case (k)
      0: return 8'hAA;
      1, 4: return 8'h55;
      2: return (op == 0) ? 8'hA0 : 8'h80;
      3: return (op == 0) ? d : 8'hAA;
      default: return (op == 2) ? 8'h30 : 8'h10;
    endcase
  endfunction

  task automatic run_op(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                        input int br, input int lim);
    int c0, dd, s, lim_e, p, e_err, waited;
    string rq;
    rq = (op == 0) ? "R3" : ((op == 1) ? "R4" : "R5");
    s = (op == 0) ? 4 : 6;
    lim_e = (lim == 0) ? 1 : lim;
    if (br < lim_e) begin p = br + 1; e_err = 0; end
    else begin p = lim_e; e_err = 1; end
    dd = s * (1 + LO + HI) + p * (RC + 1);

    wr_n = 0; rd_n = 0; rd_bad = 0; busy_reads = br; exp_rd_a = a;
    busy_val  = (op == 0) ? (d ^ 8'h80) : 8'h00;
    ready_val = (op == 0) ? d : 8'hFF;
    rec_en = 1'b1;

    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_data = d;
    poll_limit = PW'(lim);
    @(negedge clk);
    check(busy === 1'b1, "R2", "busy after accept", busy, 1);
    c0 = cyc;
    // request while busy must be ignored
    req_op = 2'd1; req_addr = a ^ 20'h0F0F0; req_data = ~d; poll_limit = PW'(1);
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (done !== 1'b1 && waited < 2000) begin @(negedge clk); waited++; end
    check(waited < 2000, "R11", "done seen", waited, 0);
    check(cyc - c0 == dd, "R11", "done cycle", cyc - c0, dd);
    check(err === 1'(e_err), "R10", "error flag", err, e_err);
    check(rd_n == p, (op == 0) ? "R8" : "R9", "status reads", rd_n, p);
    check(rd_bad == 0, "R7", "read address", rd_bad, 0);
    check(wr_n == s, rq, "write count", wr_n, s);
    for (int k = 0; k < s && k < 8; k++) begin
      check(wr_a[k] == exp_wa(op, k, a), rq, "write addr", wr_a[k], exp_wa(op, k, a));
      check(wr_d[k] == exp_wd(op, k, d), rq, "write data", wr_d[k], exp_wd(op, k, d));
    end
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R11", "idle after done", {busy, done}, 0);
    rec_en = 1'b0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wr_n = 0; rd_n = 0; rd_bad = 0; busy_reads = 0;
    busy_val = 8'h00; ready_val = 8'hFF; exp_rd_a = '0; lat_a = '0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1", "status in reset",
          {busy, done, err}, 0);
    check(we_n === 1'b1 && oe_n === 1'b1 && data_oe === 1'b0, "R1", "pins in reset",
          {we_n, oe_n, data_oe}, 3'b110);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && we_n === 1'b1 && oe_n === 1'b1, "R1", "after reset",
          {busy, we_n, oe_n}, 3'b011);

    // reserved opcode ignored
    rec_en = 1'b1; wr_n = 0; rd_n = 0;
    req_valid = 1'b1; req_op = 2'd3; req_addr = 20'h12345; req_data = 8'h5A;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(busy === 1'b0, "R2", "reserved op busy", busy, 0);
    check(wr_n == 0 && rd_n == 0, "R2", "reserved op bus activity", wr_n + rd_n, 0);
    rec_en = 1'b0;

    for (int op = 0; op < 3; op++)
      for (int br = 0; br < 5; br++)
        for (int lim = 0; lim < 5; lim++)
          run_op(op, AW'(20'h40000 + op * 20'h1111 + br * 20'h0203 + lim * 20'h0031),
                 8'((br * 37 + lim * 11 + op * 5) ^ ((lim & 1) << 7)), br, lim);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule